// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Early Warning

This block supervises software by counting a slow reference clock. The reference first passes through an odd-ratio divider, which produces a clock-enable pulse once every 1, 3, 5 … 15 reference cycles. It then feeds a binary counter whose thresholds are set by a power-of-two prescale select. When the counter passes the first threshold, the block can raise an early-warning flag and an interrupt request. This gives software a chance to recover. If software does not kick the watchdog before the count reaches twice that threshold, the block emits a one-cycle reset request and starts over.

Software programs the block through a single-cycle write strobe. Each write loads the divider select, the prescale select and the warning enable, and it can also clear the flag. A kick input restarts both intervals. An acknowledge input clears the flag when the interrupt is taken. The divided clock is never used as a clock: every register runs on the reference clock.

The control is a three-state machine with these states:
- `ST_EARLY`: counting toward the warning threshold.
- `ST_LATE`: warning passed, counting toward the final threshold.
- `ST_BITE`: the single cycle in which the reset request is driven.

It has these transitions:
- *warn* (`ST_EARLY`→`ST_LATE`) on the warning hit.
- *bite* (`ST_LATE`→`ST_BITE`) on the final hit.
- *rearm* (`ST_BITE`→`ST_EARLY`) unconditionally.
- *restart* (any state→`ST_EARLY`) on a kick or a change of divider or prescale select.

Top module: `wdog_twostage`

## Requirements
- R1: The divider select code k (0 to 7) makes the count advance once every 2k+1 reference clock cycles.
- R2: With prescale code p in 0..9, the warning threshold is EW = 2^(BASE_LOG2+p) divided ticks after a restart. When enabled, the flag reads one EW×(2k+1) cycles after the restarting edge.
- R3: Prescale codes 10 to 15 behave exactly as code 9.
- R4: The reset request goes high for exactly one cycle, 2×EW×(2k+1) cycles after a restart, and counting then restarts from zero.
- R5: The warning flag is set at the warning threshold only if the warning enable bit is one; otherwise it stays zero.
- R6: A one on the acknowledge input clears the warning flag on the next edge.
- R7: A write with the flag-clear bit at one clears the flag. A write with that bit at zero leaves the flag unchanged.
- R8: If the hardware sets the flag in the same cycle as a clear by write or by acknowledge, the set wins and the flag reads one.
- R9: The interrupt request equals flag AND warning enable AND global interrupt enable.
- R10: A kick restarts the divider and the counter, so that both thresholds are measured again from the kick edge.
- R11: A write that changes the divider or prescale select restarts the count from that write edge.
- R12: After reset the divider code is 0, the prescale code is 0, the warning enable is 0, the flag is 0, and both requests are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Low-frequency reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_div | input | 3 | Divider select written on wr_en |
| wr_pre | input | 4 | Prescale select written on wr_en |
| wr_warn_en | input | 1 | Warning enable written on wr_en |
| wr_flag_clr | input | 1 | With wr_en, one clears the warning flag |
| kick | input | 1 | Watchdog service pulse, restarts counting |
| gie | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Interrupt acknowledge, clears the flag |
| ew_flag | output | 1 | Early-warning flag |
| irq_req | output | 1 | Early-warning interrupt request |
| rst_req | output | 1 | One-cycle watchdog reset request |

## Verification
The hardware setting of the warning flag can coincide with a software clear, either a write with the clear bit or an acknowledge. The bench counts divided cycles from a restarting write and places a clear-bearing write, and separately an acknowledge, exactly on the edge where the threshold is reached. It expects the flag to read one afterwards. A configuration change that lands in the middle of an interval is also timed. The new thresholds must be measured from the change edge, which gives a result different from the one a running count would give.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int DIV_W = 3;
    localparam int PRE_W = 4;

    typedef enum logic [1:0] {
        ST_EARLY = 2'd0,
        ST_LATE  = 2'd1,
        ST_BITE  = 2'd2
    } wdt_state_e;
endpackage

// File: rtl/wdt_odd_div.sv
module wdt_odd_div #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int CW = SEL_W + 1;

    logic [CW-1:0] dcnt;
    logic [CW-1:0] last;

    // ratio is 2*sel+1, so the terminal value is 2*sel
    assign last = {sel, 1'b0};
    assign tick = (dcnt == last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       dcnt <= '0;
        else if (restart) dcnt <= '0;
        else if (tick)    dcnt <= '0;
        else              dcnt <= dcnt + CW'(1);
    end

    AST_DIV_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        dcnt <= last); // R1
endmodule

// File: rtl/wdt_tick_counter.sv
module wdt_tick_counter #(
    parameter int BASE_LOG2 = 11,
    parameter int PRE_MAX   = 9,
    parameter int PRE_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             tick,
    input  logic [PRE_W-1:0] pre,
    output logic             early_hit,
    output logic             final_hit
);
    localparam int MW = BASE_LOG2 + PRE_MAX + 2;

    logic [PRE_W-1:0] pre_eff;
    logic [MW-1:0]    mcnt;
    logic [MW-1:0]    ew_last;
    logic [MW-1:0]    fin_last;

    always_comb begin
        pre_eff  = (pre > PRE_W'(PRE_MAX)) ? PRE_W'(PRE_MAX) : pre;
        ew_last  = (MW'(1) << (BASE_LOG2 + int'(pre_eff))) - MW'(1);
        fin_last = (MW'(1) << (BASE_LOG2 + 1 + int'(pre_eff))) - MW'(1);
    end

    assign early_hit = tick && (mcnt == ew_last);
    assign final_hit = tick && (mcnt == fin_last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    mcnt <= '0;
        else if (restart || final_hit) mcnt <= '0;
        else if (tick)                 mcnt <= mcnt + MW'(1);
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        mcnt <= fin_last); // R4
endmodule

// File: rtl/wdog_twostage.sv
module wdog_twostage
    import wdt_pkg::*;
#(
    parameter int BASE_LOG2 = 11,
    parameter int PRE_MAX   = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [DIV_W-1:0] wr_div,
    input  logic [PRE_W-1:0] wr_pre,
    input  logic             wr_warn_en,
    input  logic             wr_flag_clr,
    input  logic             kick,
    input  logic             gie,
    input  logic             irq_ack,
    output logic             ew_flag,
    output logic             irq_req,
    output logic             rst_req
);
    wdt_state_e       state_q, state_d;
    logic [DIV_W-1:0] div_q;
    logic [PRE_W-1:0] pre_q;
    logic             warn_en_q;
    logic             flag_q;
    logic             cfg_change, restart, tick, early_hit, final_hit;
    logic             warn_evt, sw_clear;

    assign cfg_change = wr_en && ((wr_div != div_q) || (wr_pre != pre_q));
    assign restart    = kick || cfg_change;
    assign sw_clear   = (wr_en && wr_flag_clr) || irq_ack;

    wdt_odd_div #(.SEL_W(DIV_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .sel     (div_q),
        .tick    (tick)
    );

    wdt_tick_counter #(.BASE_LOG2(BASE_LOG2), .PRE_MAX(PRE_MAX), .PRE_W(PRE_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .tick      (tick),
        .pre       (pre_q),
        .early_hit (early_hit),
        .final_hit (final_hit)
    );

    // configuration register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q     <= '0;
            pre_q     <= '0;
            warn_en_q <= 1'b0;
        end else if (wr_en) begin
            div_q     <= wr_div;
            pre_q     <= wr_pre;
            warn_en_q <= wr_warn_en;
        end
    end

    // next-state logic: warn, bite, rearm, restart
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EARLY: if (restart) state_d = ST_EARLY;
                      else if (early_hit) state_d = ST_LATE;
            ST_LATE:  if (restart) state_d = ST_EARLY;
                      else if (final_hit) state_d = ST_BITE;
            ST_BITE:  state_d = ST_EARLY;
            default:  state_d = ST_EARLY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EARLY;
        else        state_q <= state_d;
    end

    // hardware set takes priority over any clear
    assign warn_evt = (state_q == ST_EARLY) && !restart && early_hit && warn_en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (warn_evt) flag_q <= 1'b1;
        else if (sw_clear) flag_q <= 1'b0;
    end

    // outputs
    always_comb begin
        rst_req = (state_q == ST_BITE);
        ew_flag = flag_q;
        irq_req = flag_q && warn_en_q && gie;
    end

    AST_BITE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req); // R4
    AST_FLAG_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(warn_en_q)); // R5
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !sw_clear) |=> flag_q); // R7
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (warn_evt && sw_clear) |=> flag_q); // R8
    AST_IRQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> gie); // R9
    AST_KICK_NO_BITE: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> !rst_req); // R10
endmodule

// File: tb/wdog_twostage_bench.sv
module wdog_twostage_bench;
    localparam int CLK_P = 10;
    localparam int BL    = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_div = '0;
    logic [3:0] wr_pre = '0;
    logic       wr_warn_en = 1'b0;
    logic       wr_flag_clr = 1'b0;
    logic       kick = 1'b0;
    logic       gie = 1'b0;
    logic       irq_ack = 1'b0;
    logic       ew_flag, irq_req, rst_req;

    int checks = 0;
    int errors = 0;

    always #(CLK_P/2) clk = ~clk;

    wdog_twostage #(.BASE_LOG2(BL), .PRE_MAX(9)) u_wdog_twostage (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_div(wr_div), .wr_pre(wr_pre),
        .wr_warn_en(wr_warn_en), .wr_flag_clr(wr_flag_clr), .kick(kick), .gie(gie),
        .irq_ack(irq_ack), .ew_flag(ew_flag), .irq_req(irq_req), .rst_req(rst_req)
    );

    function automatic int ew_cycles(input int d, input int p);
        int pe = (p > 9) ? 9 : p;
        return (1 << (BL + pe)) * (2 * d + 1);
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // drive at a negedge, take effect on the next posedge, return at the following negedge
    task automatic write_cfg(input int d, input int p, input bit we, input bit clr, input bit k);
        wr_en = 1'b1; wr_div = 3'(d); wr_pre = 4'(p);
        wr_warn_en = we; wr_flag_clr = clr; kick = k;
        @(negedge clk);
        wr_en = 1'b0; wr_flag_clr = 1'b0; kick = 1'b0;
    endtask

    // counts edges from the restarting edge; expects the flag clear at entry
    task automatic measure(input int d, input int p, input bit we, input string tag);
        int ew = ew_cycles(d, p);
        int first_flag = -1;
        int first_rst = -1;
        for (int k = 1; k <= 4 * ew + 10; k++) begin
            @(negedge clk);
            if (ew_flag && first_flag < 0) first_flag = k;
            if (rst_req) begin first_rst = k; break; end
        end
        chk(first_rst == 2 * ew, {tag, " R4 R1 reset request time"}, first_rst, 2 * ew);
        if (we) chk(first_flag == ew, {tag, " R2 warning time"}, first_flag, ew);
        else    chk(first_flag == -1, {tag, " R5 flag without enable"}, first_flag, -1);
        chk(irq_req == (ew_flag && we && gie), {tag, " R9 irq gating"}, irq_req, ew_flag && we && gie);
        @(negedge clk);
        chk(rst_req == 1'b0, {tag, " R4 one-cycle reset request"}, rst_req, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R4 watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk(!ew_flag && !irq_req && !rst_req, "R12 outputs in reset", {ew_flag, irq_req, rst_req}, 0);
        rst_n = 1'b1;
        // reset config: div 0, pre 0, warn enable 0
        measure(0, 0, 1'b0, "R12 default config");

        // random configurations, each restarted by a kick
        for (int i = 0; i < 8; i++) begin
            int d = int'($urandom % 8);
            int p = int'($urandom % 6);
            bit we = 1'($urandom % 2);
            gie = 1'($urandom % 2);
            write_cfg(d, p, we, 1'b1, 1'b1);
            measure(d, p, we, $sformatf("rand%0d R1 R2", i));
        end

        // reserved prescale codes
        gie = 1'b1;
        write_cfg(0, 13, 1'b0, 1'b1, 1'b1);
        measure(0, 13, 1'b0, "R3 code13");
        write_cfg(1, 15, 1'b1, 1'b1, 1'b1);
        measure(1, 15, 1'b1, "R3 code15");

        // kick postpones the reset request
        begin
            int first_rst = -1;
            write_cfg(1, 1, 1'b1, 1'b1, 1'b1);   // EW = 24 cycles
            repeat (30) @(negedge clk);
            chk(ew_flag == 1'b1, "R2 flag before kick", ew_flag, 1);
            kick = 1'b1; @(negedge clk); kick = 1'b0;
            for (int k = 1; k <= 200; k++) begin
                @(negedge clk);
                if (rst_req) begin first_rst = k; break; end
            end
            chk(first_rst == 48, "R10 kick restart", first_rst, 48);
        end

        // write zero leaves flag, write one clears (same config, no restart)
        write_cfg(1, 1, 1'b1, 1'b0, 1'b0);
        chk(ew_flag == 1'b1, "R7 write zero no effect", ew_flag, 1);
        write_cfg(1, 1, 1'b1, 1'b1, 1'b0);
        chk(ew_flag == 1'b0, "R7 write one clears", ew_flag, 0);

        // acknowledge clears
        for (int k = 0; k < 100 && !ew_flag; k++) @(negedge clk);
        chk(irq_req == 1'b1, "R9 irq with gie", irq_req, 1);
        gie = 1'b0; #1;
        chk(irq_req == 1'b0, "R9 irq masked by gie", irq_req, 0);
        gie = 1'b1;
        irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
        chk(ew_flag == 1'b0, "R6 ack clears", ew_flag, 0);

        // set wins over write clear on the same edge (EW = 4)
        write_cfg(0, 0, 1'b1, 1'b1, 1'b1);
        repeat (3) @(negedge clk);
        write_cfg(0, 0, 1'b1, 1'b1, 1'b0);
        chk(ew_flag == 1'b1, "R8 set beats write clear", ew_flag, 1);

        // set wins over acknowledge on the same edge
        write_cfg(0, 0, 1'b1, 1'b1, 1'b1);
        repeat (3) @(negedge clk);
        irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
        chk(ew_flag == 1'b1, "R8 set beats ack", ew_flag, 1);

        // configuration change mid-interval restarts the count
        write_cfg(0, 2, 1'b1, 1'b1, 1'b1);     // EW = 16
        repeat (10) @(negedge clk);
        write_cfg(0, 1, 1'b1, 1'b1, 1'b0);     // EW = 8, no kick
        measure(0, 1, 1'b1, "R11 config change");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule